// File: doc/BRIEF.md
# DMA Channel Address Generator

This block holds the transfer state of eight DMA channels and builds the physical memory address for each transfer. Each channel keeps a 16-bit base and current address, a 16-bit base and current count, a direction flag and an auto-initialize flag. Every channel also has an 8-bit page register that supplies the upper address bits. Channels 0 to 3 move bytes. Channels 5 to 7 move 16-bit words. Channel 4 is the cascade link between the two controllers and never carries a transfer.

A host loads a channel through a single configuration strobe, which also arms the channel. It writes and reads page registers through byte-wide I/O ports. A transfer engine pulses `xfer_req` with a channel number. The block then shows the address of that transfer on `phys_addr` in the same cycle, and on the clock edge it steps the channel's address and count. When a transfer takes the last unit, the channel raises its terminal-count bit for one cycle. After that the channel either reloads from its base values or parks itself.

Each channel runs a two-state machine. PARKED is the reset state and the state after terminal count without auto-initialize. RUNNING is the state after a load. The transitions are: ARM (PARKED to RUNNING on a load), RELOAD (RUNNING to RUNNING on a load, or on terminal count with auto-initialize), STEP (RUNNING to RUNNING on a transfer while the count is above zero) and EXPIRE (RUNNING to PARKED on terminal count without auto-initialize).

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, every channel is PARKED (`chan_active` = 0), every page register reads 0 and `tc_vec` = 0.
- R2: `cfg_we` with `cfg_ch` sets both base and current address to `cfg_addr` and both counts to `cfg_count`. It latches `cfg_down` (1 = decrement) and `cfg_auto`, and sets that channel's `chan_active` bit on the next cycle. A load to channel 4 has no effect.
- R3: For channels 0 to 3, `phys_addr` = {page, current address}, taken from the channel selected by `xfer_ch` in the same cycle.
- R4: For channels 5 to 7, `phys_addr` = {page[7:1], current address, 1'b0}.
- R5: A transfer on a running channel whose count is above zero steps the address by +1 (or -1 when the down flag is set) and lowers the count by 1. A count of N therefore gives N+1 transfers.
- R6: A transfer on a running channel whose count is 0 sets bit `ch` of `tc_vec` for exactly the next cycle.
- R7: At terminal count with auto-initialize set, the current address and count reload from base and the channel stays running. Without auto-initialize, the address still steps and the channel parks.
- R8: A transfer on a parked channel, or on channel 4, changes nothing. For channel 4, `phys_addr` reads 0.
- R9: Page ports map to channels as follows: 0x81 to 2, 0x82 to 3, 0x83 to 1, 0x89 to 6, 0x8A to 7, 0x8B to 5. A write with `io_wr` takes effect on the next edge. `io_hit` flags a mapped port. While `io_rd` is high on a mapped port, `io_rdata` returns that channel's page; otherwise it reads 0.
- R10: When a load and a transfer hit the same channel in one cycle, the load wins. A page write in the same cycle as a transfer does not change that transfer's address; the new page applies from the next cycle.
- R11: The 16-bit current address wraps from 0xFFFF to 0x0000 (and back) without carrying into the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for one channel |
| cfg_ch | input | 3 | Channel to load |
| cfg_addr | input | 16 | Start address |
| cfg_count | input | 16 | Transfer count minus one |
| cfg_auto | input | 1 | Auto-initialize enable |
| cfg_down | input | 1 | 1 = address decrements |
| xfer_req | input | 1 | Transfer strobe |
| xfer_ch | input | 3 | Channel of the transfer |
| phys_addr | output | 24 | Physical address of the selected channel |
| tc_vec | output | 8 | One-cycle terminal-count pulse per channel |
| chan_active | output | 8 | Channel is RUNNING |
| io_wr | input | 1 | Page port write |
| io_rd | input | 1 | Page port read |
| io_port | input | 8 | Low byte of the I/O port number |
| io_wdata | input | 8 | Page write data |
| io_rdata | output | 8 | Page read-back data |
| io_hit | output | 1 | Port number is a page port |

## Verification
Two functions can meet in the same cycle. A load can arrive in the cycle a transfer strikes the same channel, and a page write can arrive in the cycle a transfer reads that page. The bench forces both collisions on purpose: a load lands on a running channel mid-transfer, and port 0x82 is written while channel 3 transfers. Random traffic then produces more such collisions. A behavioural model applies the load-wins and old-page-this-cycle rules, and every output is compared with it on every clock.

// File: rtl/dmaag_pkg.sv
package dmaag_pkg;

    typedef enum logic {
        CH_PARKED  = 1'b0,
        CH_RUNNING = 1'b1
    } ch_state_e;

    // Page-port decode: returns {hit, channel}. The channel order is fixed behaviour.
    function automatic logic [3:0] page_port_decode(input logic [7:0] port);
        logic [3:0] r;
        unique case (port)
            8'h81:   r = 4'b1_010;
            8'h82:   r = 4'b1_011;
            8'h83:   r = 4'b1_001;
            8'h89:   r = 4'b1_110;
            8'h8A:   r = 4'b1_111;
            8'h8B:   r = 4'b1_101;
            default: r = 4'b0_000;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dmaag_page_file.sv
module dmaag_page_file
    import dmaag_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int PAGE_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           io_wr,
    input  logic                           io_rd,
    input  logic [7:0]                     io_port,
    input  logic [PAGE_W-1:0]              io_wdata,
    output logic [PAGE_W-1:0]              io_rdata,
    output logic                           io_hit,
    output logic [NUM_CH-1:0][PAGE_W-1:0]  pages
);
    localparam int CH_W = $clog2(NUM_CH);

    logic [3:0]      dec;
    logic [CH_W-1:0] sel;

    always_comb begin
        dec    = page_port_decode(io_port);
        io_hit = dec[3];
        sel    = CH_W'(dec[2:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pages <= '0;
        end else if (io_wr && io_hit) begin
            pages[sel] <= io_wdata;
        end
    end

    always_comb begin
        io_rdata = '0;
        if (io_rd && io_hit) io_rdata = pages[sel];
    end

endmodule

// File: rtl/dmaag_channel.sv
module dmaag_channel
    import dmaag_pkg::*;
#(
    parameter int PAGE_W    = 8,
    parameter int OFS_W     = 16,
    parameter bit WORD_MODE = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [OFS_W-1:0]          ld_addr,
    input  logic [OFS_W-1:0]          ld_count,
    input  logic                      ld_auto,
    input  logic                      ld_down,
    input  logic                      step,
    input  logic [PAGE_W-1:0]         page,
    output logic [PAGE_W+OFS_W-1:0]   phys,
    output logic                      running,
    output logic                      tc
);
    ch_state_e         state, state_nxt;
    logic [OFS_W-1:0]  base_a, base_c, cur_a, cur_c, next_a;
    logic              auto_q, down_q, last_unit;

    assign last_unit = (cur_c == '0);
    assign next_a    = down_q ? cur_a - 1'b1 : cur_a + 1'b1;

    // Next-state logic: ARM, RELOAD, STEP, EXPIRE
    always_comb begin
        state_nxt = state;
        unique case (state)
            CH_PARKED:  if (load) state_nxt = CH_RUNNING;
            CH_RUNNING: if (!load && step && last_unit && !auto_q)
                            state_nxt = CH_PARKED;
            default:    state_nxt = CH_PARKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_PARKED;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_a <= '0; base_c <= '0; cur_a <= '0; cur_c <= '0;
            auto_q <= 1'b0; down_q <= 1'b0; tc <= 1'b0;
        end else begin
            tc <= 1'b0;
            if (load) begin
                base_a <= ld_addr;  cur_a <= ld_addr;
                base_c <= ld_count; cur_c <= ld_count;
                auto_q <= ld_auto;  down_q <= ld_down;
            end else if (step && state == CH_RUNNING) begin
                if (last_unit) begin
                    tc <= 1'b1;
                    if (auto_q) begin
                        cur_a <= base_a;
                        cur_c <= base_c;
                    end else begin
                        cur_a <= next_a;
                    end
                end else begin
                    cur_a <= next_a;
                    cur_c <= cur_c - 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb running = (state == CH_RUNNING);

    generate
        if (WORD_MODE) begin : g_word
            always_comb phys = {page[PAGE_W-1:1], cur_a, 1'b0};
        end else begin : g_byte
            always_comb phys = {page, cur_a};
        end
    endgenerate

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dmaag_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int CASCADE_CH = 4,
    parameter int WORD_FIRST = 4,
    parameter int PAGE_W     = 8,
    parameter int OFS_W      = 16,
    localparam int CH_W      = $clog2(NUM_CH),
    localparam int PHYS_W    = PAGE_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [OFS_W-1:0]  cfg_addr,
    input  logic [OFS_W-1:0]  cfg_count,
    input  logic              cfg_auto,
    input  logic              cfg_down,
    input  logic              xfer_req,
    input  logic [CH_W-1:0]   xfer_ch,
    output logic [PHYS_W-1:0] phys_addr,
    output logic [NUM_CH-1:0] tc_vec,
    output logic [NUM_CH-1:0] chan_active,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_port,
    input  logic [PAGE_W-1:0] io_wdata,
    output logic [PAGE_W-1:0] io_rdata,
    output logic              io_hit
);
    logic [NUM_CH-1:0][PAGE_W-1:0] pages;
    logic [NUM_CH-1:0][PHYS_W-1:0] phys_arr;

    dmaag_page_file #(.NUM_CH(NUM_CH), .PAGE_W(PAGE_W)) u_pages (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_port(io_port), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_hit(io_hit), .pages(pages)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            if (g == CASCADE_CH) begin : g_link
                assign phys_arr[g]    = '0;
                assign chan_active[g] = 1'b0;
                assign tc_vec[g]      = 1'b0;
            end else begin : g_xfer
                dmaag_channel #(
                    .PAGE_W(PAGE_W), .OFS_W(OFS_W),
                    .WORD_MODE(g >= WORD_FIRST)
                ) u_ch (
                    .clk(clk), .rst_n(rst_n),
                    .load(cfg_we && cfg_ch == CH_W'(g)),
                    .ld_addr(cfg_addr), .ld_count(cfg_count),
                    .ld_auto(cfg_auto), .ld_down(cfg_down),
                    .step(xfer_req && xfer_ch == CH_W'(g)),
                    .page(pages[g]), .phys(phys_arr[g]),
                    .running(chan_active[g]), .tc(tc_vec[g])
                );
            end
        end
    endgenerate

    assign phys_addr = phys_arr[xfer_ch];

endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk #(
    parameter int NUM_CH     = 8,
    parameter int CASCADE_CH = 4,
    parameter int WORD_FIRST = 4,
    parameter int PAGE_W     = 8,
    parameter int CH_W       = 3,
    parameter int PHYS_W     = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [CH_W-1:0]   cfg_ch,
    input logic              xfer_req,
    input logic [CH_W-1:0]   xfer_ch,
    input logic [PHYS_W-1:0] phys_addr,
    input logic [NUM_CH-1:0] tc_vec,
    input logic [NUM_CH-1:0] chan_active,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_port,
    input logic [PAGE_W-1:0] io_wdata,
    input logic [PAGE_W-1:0] io_rdata,
    input logic              io_hit
);
    // R6
    tc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tc_vec));

    // R6
    tc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_vec != '0) |-> ($past(xfer_req) && (($past(chan_active) & tc_vec) == tc_vec)));

    // R2
    load_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_ch != CH_W'(CASCADE_CH)) |=> chan_active[$past(cfg_ch)]);

    // R9
    page_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_hit) |=> (!(io_rd && io_port == $past(io_port)) || io_rdata == $past(io_wdata)));

    // R4
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ch >= CH_W'(WORD_FIRST)) |-> !phys_addr[0]);

endmodule

bind dma_addr_gen dma_addr_gen_chk #(
    .NUM_CH(NUM_CH), .CASCADE_CH(CASCADE_CH), .WORD_FIRST(WORD_FIRST),
    .PAGE_W(PAGE_W), .CH_W(CH_W), .PHYS_W(PHYS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .xfer_req(xfer_req), .xfer_ch(xfer_ch), .phys_addr(phys_addr),
    .tc_vec(tc_vec), .chan_active(chan_active), .io_wr(io_wr), .io_rd(io_rd),
    .io_port(io_port), .io_wdata(io_wdata), .io_rdata(io_rdata), .io_hit(io_hit)
);

// File: tb/dma_addr_gen_test.sv
`timescale 1ns/1ps
module dma_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 0, cfg_auto = 0, cfg_down = 0, xfer_req = 0;
    logic [2:0]  cfg_ch = 0, xfer_ch = 0;
    logic [15:0] cfg_addr = 0, cfg_count = 0;
    logic        io_wr = 0, io_rd = 0;
    logic [7:0]  io_port = 0, io_wdata = 0;
    logic [23:0] phys_addr;
    logic [7:0]  tc_vec, chan_active, io_rdata;
    logic        io_hit;

    int checks = 0, failures = 0;
    string phase = "R1";

    // model state
    int m_page[8], m_ba[8], m_bc[8], m_ca[8], m_cc[8];
    bit m_act[8], m_auto[8], m_down[8];
    int m_tc;

    always #2 clk = ~clk;

    dma_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_addr(cfg_addr), .cfg_count(cfg_count), .cfg_auto(cfg_auto),
        .cfg_down(cfg_down), .xfer_req(xfer_req), .xfer_ch(xfer_ch),
        .phys_addr(phys_addr), .tc_vec(tc_vec), .chan_active(chan_active),
        .io_wr(io_wr), .io_rd(io_rd), .io_port(io_port), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_hit(io_hit)
    );

    function automatic int port_ch(input int p);
        case (p)
            'h81: return 2; 'h82: return 3; 'h83: return 1;
            'h89: return 6; 'h8A: return 7; 'h8B: return 5;
            default: return -1;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s (%s) %s: actual=%h expected=%h", req, phase, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_page[i] = 0; m_ba[i] = 0; m_bc[i] = 0; m_ca[i] = 0; m_cc[i] = 0;
            m_act[i] = 0; m_auto[i] = 0; m_down[i] = 0;
        end
        m_tc = 0;
    endtask

    task automatic compare();
        int ch, a, p, exp_phys, act_v, pc;
        ch = xfer_ch; a = m_ca[ch]; p = m_page[ch];
        if (ch == 4)      exp_phys = 0;
        else if (ch >= 4) exp_phys = ((p >> 1) << 17) | (a << 1);
        else              exp_phys = (p << 16) | a;
        chk((ch == 4) ? "R8" : (ch >= 4) ? "R4" : "R3", "phys_addr", int'(phys_addr), exp_phys);
        chk("R6", "tc_vec", int'(tc_vec), m_tc);
        act_v = 0;
        for (int i = 0; i < 8; i++) if (m_act[i]) act_v |= (1 << i);
        chk("R7", "chan_active", int'(chan_active), act_v);
        pc = port_ch(io_port);
        chk("R9", "io_hit", int'(io_hit), (pc >= 0) ? 1 : 0);
        chk("R9", "io_rdata", int'(io_rdata), (io_rd && pc >= 0) ? m_page[pc] : 0);
    endtask

    task automatic model_update();
        int ld, xc, pc;
        ld = (cfg_we && cfg_ch != 4) ? int'(cfg_ch) : -1;
        m_tc = 0;
        xc = xfer_ch;
        if (xfer_req && xc != ld && m_act[xc]) begin
            if (m_cc[xc] == 0) begin
                m_tc = 1 << xc;
                if (m_auto[xc]) begin
                    m_ca[xc] = m_ba[xc]; m_cc[xc] = m_bc[xc];
                end else begin
                    m_ca[xc] = (m_ca[xc] + (m_down[xc] ? -1 : 1)) & 'hFFFF;
                    m_act[xc] = 0;
                end
            end else begin
                m_ca[xc] = (m_ca[xc] + (m_down[xc] ? -1 : 1)) & 'hFFFF;
                m_cc[xc] = m_cc[xc] - 1;
            end
        end
        if (ld >= 0) begin
            m_ba[ld] = cfg_addr; m_ca[ld] = cfg_addr;
            m_bc[ld] = cfg_count; m_cc[ld] = cfg_count;
            m_auto[ld] = cfg_auto; m_down[ld] = cfg_down; m_act[ld] = 1;
        end
        pc = port_ch(io_port);
        if (io_wr && pc >= 0) m_page[pc] = io_wdata;
    endtask

    // Inputs are set just after a negedge; tick compares, updates the model at the edge,
    // then returns just after the next negedge with inputs back at idle.
    task automatic tick();
        #1 compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
        cfg_we = 0; xfer_req = 0; io_wr = 0; io_rd = 0;
    endtask

    task automatic load(input int ch, input int a, input int c, input bit au, input bit dn);
        cfg_we = 1; cfg_ch = 3'(ch); cfg_addr = 16'(a); cfg_count = 16'(c);
        cfg_auto = au; cfg_down = dn;
    endtask

    task automatic xfer(input int ch, input int n);
        for (int k = 0; k < n; k++) begin
            xfer_req = 1; xfer_ch = 3'(ch); tick();
        end
    endtask

    task automatic page_wr(input int port, input int v);
        io_wr = 1; io_port = 8'(port); io_wdata = 8'(v);
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        summary();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        phase = "R1";
        tick(); tick();
        for (int p = 'h80; p <= 'h8F; p++) begin io_rd = 1; io_port = 8'(p); tick(); end

        // R9: page writes through the scrambled port map, plus unmapped ports
        phase = "R9";
        page_wr('h81, 'h12); tick(); page_wr('h82, 'h34); tick();
        page_wr('h83, 'h56); tick(); page_wr('h89, 'h9B); tick();
        page_wr('h8A, 'hCD); tick(); page_wr('h8B, 'hEF); tick();
        page_wr('h80, 'hAA); tick(); page_wr('h87, 'h55); tick();
        for (int p = 'h80; p <= 'h8F; p++) begin io_rd = 1; io_port = 8'(p); tick(); end

        // R2, R3, R5, R6, R7: byte channel 1, count 2, up, no auto-init
        phase = "R5";
        load(1, 'h1234, 2, 0, 0); tick();
        xfer(1, 3);
        // R8: channel now parked, further strobes ignored
        phase = "R8";
        xfer(1, 2); tick();

        // R4, R7: word channel 5, down, auto-init
        phase = "R4";
        load(5, 'h8000, 1, 1, 1); tick();
        xfer(5, 5); tick();

        // R11: wrap at 0xFFFF on byte channel 2, and downward wrap on channel 0
        phase = "R11";
        load(2, 'hFFFE, 3, 0, 0); tick(); xfer(2, 4);
        load(0, 'h0001, 2, 0, 1); tick(); xfer(0, 3);

        // R2, R8: cascade channel ignores load and transfer
        phase = "R2";
        load(4, 'h4444, 0, 1, 0); tick(); xfer(4, 2);

        // R10: load collides with transfer on same running channel
        phase = "R10";
        load(3, 'h0100, 5, 0, 0); tick(); xfer(3, 2);
        load(3, 'h0200, 0, 0, 0); xfer_req = 1; xfer_ch = 3; tick();
        // R10: page write in same cycle as transfer on channel 3 (port 0x82)
        load(3, 'h0300, 4, 0, 0); tick();
        page_wr('h82, 'h77); xfer_req = 1; xfer_ch = 3; tick();
        xfer(3, 2);

        // mixed random traffic
        phase = "R10-mix";
        for (int n = 0; n < 600; n++) begin
            if ($urandom_range(0, 7) == 0)
                load($urandom_range(0, 7), $urandom_range(0, 65535),
                     $urandom_range(0, 4), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 3) != 0) begin
                xfer_req = 1; xfer_ch = 3'($urandom_range(0, 7));
            end else xfer_ch = 3'($urandom_range(0, 7));
            io_port = 8'($urandom_range('h80, 'h8F));
            io_wr = 1'($urandom_range(0, 5) == 0);
            io_rd = 1'($urandom_range(0, 1));
            io_wdata = 8'($urandom_range(0, 255));
            tick();
        end
        summary();
    end
endmodule